// File: doc/BRIEF.md
# Serial Interface Wire-Mode Controller

This block is the pin-control and clock-stretch logic of a small universal serial interface. It sits between a shift register and counter on one side and three port pins on the other: a data-output pin, a data-input pin and a clock pin. A two-bit wire-mode input picks one of four behaviours. In the off mode the three pins are plain port pins. In three-wire mode the data-output pin takes its value from the shift register. In the two two-wire modes the data-input and clock pins become open-drain lines.

In the two-wire modes the block also stretches the clock. Both lines pass through synchronizers. A start condition on the synchronized lines sets a start flag. While that flag is set, the clock line is held low wherever its direction bit enables the driver. A counter-overflow pulse sets an overflow flag. In the hold variant of two-wire mode, that flag also holds the clock line low. Software releases a hold by pulsing the matching clear strobe.

Each pin is described by three outputs: a driver enable, the value driven and a pull-up enable. An open-drain pull-low appears as driver enabled with value 0.

Top module: `usi_wire_ctrl`

## Requirements
- R1: With `mode_i` = 00 (off), every pin follows its port bits: enable = direction bit, driven value = port bit, pull-up = port bit AND NOT direction bit. The start flag never sets in this mode.
- R2: With `mode_i` = 01 (three-wire), the data-output pin drives `shift_msb_i` in place of its port bit. Its enable is still its direction bit, and its pull-up is its port bit AND NOT its direction bit.
- R3: With `mode_i` = 01, the data-input and clock pins behave as plain port pins, exactly as in R1.
- R4: With `mode_i` = 10 or 11, the data-input pin is open-drain. Its enable is `di_dir_i` AND (NOT `shift_msb_i` OR NOT `di_port_i`), and its driven value is always 0.
- R5: With `mode_i` = 10 or 11, the clock pin is open-drain. Its enable is `ck_dir_i` AND (NOT `ck_port_i` OR hold), and its driven value is always 0. Hold is the start flag, OR the overflow flag when `mode_i` = 11.
- R6: In modes 10 and 11, the pull-ups of the data-input and clock pins are 0. In every mode, `di_sync_o` and `ck_sync_o` show the raw line inputs delayed by two clocks, and both reset to 1.
- R7: A start condition is the synchronized data line going from 1 to 0 while the synchronized clock line is 1, in any mode other than 00. It sets `start_flag_o` one clock after the synchronized data line falls, which is three rising edges after the raw data line falls.
- R8: In modes 10 and 11, while `start_flag_o` is 1 and `ck_dir_i` is 1, the clock pin is pulled low even when `ck_port_i` is 1. It is released in the cycle after `start_clr_i` clears the flag.
- R9: `ovf_pulse_i` sets `ovf_flag_o` on the next edge in every mode. The flag holds the clock line low only in mode 11.
- R10: A one-cycle clear strobe clears its flag on the next edge. When a set event and a clear strobe for the same flag fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Wire mode: 00 off, 01 three-wire, 10 two-wire, 11 two-wire with overflow hold |
| shift_msb_i | input | 1 | Output bit of the shift register |
| do_port_i | input | 1 | Port bit of the data-output pin |
| do_dir_i | input | 1 | Direction bit of the data-output pin (1 = output) |
| di_port_i | input | 1 | Port bit of the data-input / two-wire data pin |
| di_dir_i | input | 1 | Direction bit of the data-input / two-wire data pin |
| ck_port_i | input | 1 | Port bit of the clock pin |
| ck_dir_i | input | 1 | Direction bit of the clock pin |
| di_line_i | input | 1 | Raw level on the data-input line |
| ck_line_i | input | 1 | Raw level on the clock line |
| ovf_pulse_i | input | 1 | One-cycle counter-overflow pulse |
| start_clr_i | input | 1 | Clear strobe for the start flag |
| ovf_clr_i | input | 1 | Clear strobe for the overflow flag |
| do_oe_o | output | 1 | Data-output pin driver enable |
| do_val_o | output | 1 | Data-output pin driven value |
| do_pu_o | output | 1 | Data-output pin pull-up enable |
| di_oe_o | output | 1 | Data-input pin driver enable |
| di_val_o | output | 1 | Data-input pin driven value |
| di_pu_o | output | 1 | Data-input pin pull-up enable |
| ck_oe_o | output | 1 | Clock pin driver enable |
| ck_val_o | output | 1 | Clock pin driven value |
| ck_pu_o | output | 1 | Clock pin pull-up enable |
| di_sync_o | output | 1 | Synchronized data line |
| ck_sync_o | output | 1 | Synchronized clock line |
| start_flag_o | output | 1 | Start-condition flag |
| ovf_flag_o | output | 1 | Counter-overflow flag |

## Verification
The hardest state to reach from the ports is a clock line held low by a start condition while the port bit asks for it to be released. Reaching it needs a falling data edge that survives the synchronizer while the clock line stays high. That edge must arrive in a two-wire mode, and the clock direction bit must be set. The stimulus drives this sequence directly, then pulses the clear strobe and watches the release. It repeats the sequence in the off mode, where no flag may appear. Overflow holds are then tried in both two-wire modes, along with a set and clear in the same cycle. A long random phase varies lines, modes and strobes, and every output is compared against a behavioural model on every clock.

// File: rtl/usi_wire_pkg.sv
package usi_wire_pkg;

  typedef enum logic [1:0] {
    WM_OFF      = 2'b00,
    WM_THREE    = 2'b01,
    WM_TWO      = 2'b10,
    WM_TWO_HOLD = 2'b11
  } wire_mode_e;

  typedef struct packed {
    logic oe;
    logic val;
    logic pu;
  } pin_drv_t;

  localparam int unsigned FLAG_START = 0;
  localparam int unsigned FLAG_OVF   = 1;
  localparam int unsigned NUM_FLAGS  = 2;

  function automatic pin_drv_t port_pin(input logic port, input logic dir);
    pin_drv_t r;
    r.oe  = dir;
    r.val = port;
    r.pu  = port & ~dir;
    return r;
  endfunction

  function automatic pin_drv_t open_drain(input logic pull_low);
    pin_drv_t r;
    r.oe  = pull_low;
    r.val = 1'b0;
    r.pu  = 1'b0;
    return r;
  endfunction

  function automatic logic is_two_wire(input wire_mode_e m);
    return (m == WM_TWO) || (m == WM_TWO_HOLD);
  endfunction

endpackage

// File: rtl/usi_line_sync.sv
module usi_line_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {(STAGES*WIDTH){RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/usi_start_det.sv
module usi_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_o
);
  logic sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_prev_q <= 1'b1;
    else         sda_prev_q <= sda_i;
  end

  // falling data edge while clock is high
  assign start_o = en_i & sda_prev_q & ~sda_i & scl_i;
endmodule

// File: rtl/usi_flag.sv
module usi_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/usi_pin_mux.sv
module usi_pin_mux
  import usi_wire_pkg::*;
(
  input  wire_mode_e mode_i,
  input  logic       shift_msb_i,
  input  logic       do_port_i,
  input  logic       do_dir_i,
  input  logic       di_port_i,
  input  logic       di_dir_i,
  input  logic       ck_port_i,
  input  logic       ck_dir_i,
  input  logic       hold_i,
  output pin_drv_t   do_drv_o,
  output pin_drv_t   di_drv_o,
  output pin_drv_t   ck_drv_o
);
  always_comb begin
    do_drv_o = port_pin(do_port_i, do_dir_i);
    di_drv_o = port_pin(di_port_i, di_dir_i);
    ck_drv_o = port_pin(ck_port_i, ck_dir_i);
    unique case (mode_i)
      WM_THREE: do_drv_o = port_pin(shift_msb_i, do_dir_i);
      WM_TWO, WM_TWO_HOLD: begin
        di_drv_o = open_drain(di_dir_i & ~(shift_msb_i & di_port_i));
        ck_drv_o = open_drain(ck_dir_i & (~ck_port_i | hold_i));
      end
      default: ;
    endcase
    // the pull-up of the data-output pin still follows its port bit
    do_drv_o.pu = do_port_i & ~do_dir_i;
  end
endmodule

// File: rtl/usi_wire_ctrl.sv
module usi_wire_ctrl
  import usi_wire_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       shift_msb_i,
  input  logic       do_port_i,
  input  logic       do_dir_i,
  input  logic       di_port_i,
  input  logic       di_dir_i,
  input  logic       ck_port_i,
  input  logic       ck_dir_i,
  input  logic       di_line_i,
  input  logic       ck_line_i,
  input  logic       ovf_pulse_i,
  input  logic       start_clr_i,
  input  logic       ovf_clr_i,
  output logic       do_oe_o,
  output logic       do_val_o,
  output logic       do_pu_o,
  output logic       di_oe_o,
  output logic       di_val_o,
  output logic       di_pu_o,
  output logic       ck_oe_o,
  output logic       ck_val_o,
  output logic       ck_pu_o,
  output logic       di_sync_o,
  output logic       ck_sync_o,
  output logic       start_flag_o,
  output logic       ovf_flag_o
);
  localparam int unsigned LINES = 2;

  wire_mode_e           mode;
  logic [LINES-1:0]     line_sync;
  logic                 start_evt;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic                 hold;
  pin_drv_t             do_drv, di_drv, ck_drv;

  assign mode = wire_mode_e'(mode_i);

  usi_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ck_line_i, di_line_i}),
    .q_o   (line_sync)
  );

  assign di_sync_o = line_sync[0];
  assign ck_sync_o = line_sync[1];

  usi_start_det u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode != WM_OFF),
    .sda_i  (line_sync[0]),
    .scl_i  (line_sync[1]),
    .start_o(start_evt)
  );

  assign flag_set[FLAG_START] = start_evt;
  assign flag_clr[FLAG_START] = start_clr_i;
  assign flag_set[FLAG_OVF]   = ovf_pulse_i;
  assign flag_clr[FLAG_OVF]   = ovf_clr_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    usi_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .flag_o(flag_q[g])
    );
  end

  assign start_flag_o = flag_q[FLAG_START];
  assign ovf_flag_o   = flag_q[FLAG_OVF];
  assign hold = flag_q[FLAG_START] | ((mode == WM_TWO_HOLD) & flag_q[FLAG_OVF]);

  usi_pin_mux u_mux (
    .mode_i     (mode),
    .shift_msb_i(shift_msb_i),
    .do_port_i  (do_port_i),
    .do_dir_i   (do_dir_i),
    .di_port_i  (di_port_i),
    .di_dir_i   (di_dir_i),
    .ck_port_i  (ck_port_i),
    .ck_dir_i   (ck_dir_i),
    .hold_i     (hold),
    .do_drv_o   (do_drv),
    .di_drv_o   (di_drv),
    .ck_drv_o   (ck_drv)
  );

  assign {do_oe_o, do_val_o, do_pu_o} = do_drv;
  assign {di_oe_o, di_val_o, di_pu_o} = di_drv;
  assign {ck_oe_o, ck_val_o, ck_pu_o} = ck_drv;
endmodule

// File: rtl/usi_wire_ctrl_chk.sv
module usi_wire_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       shift_msb_i,
  input logic       do_dir_i,
  input logic       ck_dir_i,
  input logic       ovf_pulse_i,
  input logic       ovf_clr_i,
  input logic       do_oe_o,
  input logic       do_val_o,
  input logic       di_val_o,
  input logic       di_pu_o,
  input logic       ck_oe_o,
  input logic       ck_val_o,
  input logic       ck_pu_o,
  input logic       start_flag_o,
  input logic       ovf_flag_o
);
  assert_off_no_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !start_flag_o) |=> !start_flag_o);

  assert_three_do_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && do_dir_i) |-> (do_oe_o && do_val_o == shift_msb_i));

  assert_di_never_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> !di_val_o);

  assert_two_wire_no_pu_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> (!di_pu_o && !ck_pu_o));

  assert_start_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && ck_dir_i && start_flag_o) |-> (ck_oe_o && !ck_val_o));

  assert_ovf_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && ck_dir_i && ovf_flag_o) |-> (ck_oe_o && !ck_val_o));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_pulse_i && ovf_clr_i) |=> ovf_flag_o);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !ovf_pulse_i) |=> !ovf_flag_o);
endmodule

bind usi_wire_ctrl usi_wire_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .shift_msb_i (shift_msb_i),
  .do_dir_i    (do_dir_i),
  .ck_dir_i    (ck_dir_i),
  .ovf_pulse_i (ovf_pulse_i),
  .ovf_clr_i   (ovf_clr_i),
  .do_oe_o     (do_oe_o),
  .do_val_o    (do_val_o),
  .di_val_o    (di_val_o),
  .di_pu_o     (di_pu_o),
  .ck_oe_o     (ck_oe_o),
  .ck_val_o    (ck_val_o),
  .ck_pu_o     (ck_pu_o),
  .start_flag_o(start_flag_o),
  .ovf_flag_o  (ovf_flag_o)
);

// File: tb/tb_usi_wire_ctrl.sv
module tb_usi_wire_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic shift_msb = 0, do_port = 0, do_dir = 0, di_port = 0, di_dir = 0;
  logic ck_port = 0, ck_dir = 0, di_line = 1, ck_line = 1;
  logic ovf_pulse = 0, start_clr = 0, ovf_clr = 0;
  logic do_oe, do_val, do_pu, di_oe, di_val, di_pu, ck_oe, ck_val, ck_pu;
  logic di_sync, ck_sync, start_flag, ovf_flag;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural reference state: line histories as queues, flags as bits
  bit di_hist[$];
  bit ck_hist[$];
  bit m_prev_di = 1;
  bit m_start = 0, m_ovf = 0;

  always #2 clk = ~clk;

  usi_wire_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .shift_msb_i(shift_msb),
    .do_port_i(do_port), .do_dir_i(do_dir), .di_port_i(di_port), .di_dir_i(di_dir),
    .ck_port_i(ck_port), .ck_dir_i(ck_dir), .di_line_i(di_line), .ck_line_i(ck_line),
    .ovf_pulse_i(ovf_pulse), .start_clr_i(start_clr), .ovf_clr_i(ovf_clr),
    .do_oe_o(do_oe), .do_val_o(do_val), .do_pu_o(do_pu),
    .di_oe_o(di_oe), .di_val_o(di_val), .di_pu_o(di_pu),
    .ck_oe_o(ck_oe), .ck_val_o(ck_val), .ck_pu_o(ck_pu),
    .di_sync_o(di_sync), .ck_sync_o(ck_sync),
    .start_flag_o(start_flag), .ovf_flag_o(ovf_flag)
  );

  task automatic model_reset();
    di_hist = '{1, 1};
    ck_hist = '{1, 1};
    m_prev_di = 1; m_start = 0; m_ovf = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst_n) begin
      bit s_di, s_ck, evt;
      s_di = di_hist[0];
      s_ck = ck_hist[0];
      evt = (mode != 2'b00) && m_prev_di && !s_di && s_ck;
      m_start = evt ? 1'b1 : (start_clr ? 1'b0 : m_start);
      m_ovf = ovf_pulse ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
      m_prev_di = s_di;
      void'(di_hist.pop_front());
      void'(ck_hist.pop_front());
      di_hist.push_back(di_line);
      ck_hist.push_back(ck_line);
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input bit exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit two, hold;
    bit e_oe, e_val, e_pu;
    string t;
    vectors++;
    two  = mode[1];
    hold = m_start || (mode == 2'b11 && m_ovf);
    t = (mode == 2'b01) ? "R2" : "R1";
    chk(t, "do_oe", do_oe, do_dir);
    chk(t, "do_val", do_val, (mode == 2'b01) ? shift_msb : do_port);
    chk(t, "do_pu", do_pu, do_port && !do_dir);
    if (two) begin
      chk("R4", "di_oe", di_oe, di_dir && (!shift_msb || !di_port));
      chk("R4", "di_val", di_val, 1'b0);
      chk("R5", "ck_oe", ck_oe, ck_dir && (!ck_port || hold));
      chk("R5", "ck_val", ck_val, 1'b0);
      chk("R6", "di_pu", di_pu, 1'b0);
      chk("R6", "ck_pu", ck_pu, 1'b0);
    end else begin
      t = (mode == 2'b01) ? "R3" : "R1";
      chk(t, "di_oe", di_oe, di_dir);
      chk(t, "di_val", di_val, di_port);
      chk(t, "di_pu", di_pu, di_port && !di_dir);
      chk(t, "ck_oe", ck_oe, ck_dir);
      chk(t, "ck_val", ck_val, ck_port);
      chk(t, "ck_pu", ck_pu, ck_port && !ck_dir);
    end
    chk("R6", "di_sync", di_sync, di_hist[0]);
    chk("R6", "ck_sync", ck_sync, ck_hist[0]);
    chk("R7", "start_flag", start_flag, m_start);
    chk("R9", "ovf_flag", ovf_flag, m_ovf);
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      #1 compare_all();
      start_clr = 0; ovf_clr = 0; ovf_pulse = 0;
    end
  endtask

  task automatic count_check(input string tag, input string what, input logic act, input bit exp);
    vectors++;
    chk(tag, what, act, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 compare_all();  // reset state
    count_check("R6", "reset di_sync", di_sync, 1'b1);
    count_check("R7", "reset start_flag", start_flag, 1'b0);
    rst_n = 1;
    tick(2);

    // R1: start pattern in off mode never sets the flag
    mode = 2'b00; ck_line = 1; di_line = 0;
    tick(4);
    count_check("R1", "start in off mode", start_flag, 1'b0);
    di_line = 1; tick(3);

    // R2/R3: three-wire output override
    mode = 2'b01; do_dir = 1; do_port = 0; shift_msb = 1;
    tick(1);
    count_check("R2", "do follows shift", do_val, 1'b1);
    do_dir = 0; do_port = 1; ck_dir = 1; ck_port = 1;
    tick(1);
    count_check("R3", "ck port pin", ck_val, 1'b1);

    // R7/R8: start in two-wire mode, clock held low, then released
    mode = 2'b10; ck_dir = 1; ck_port = 1; di_dir = 1; di_port = 1;
    tick(2);
    di_line = 0;
    tick(2);
    count_check("R7", "flag not yet set", start_flag, 1'b0);
    tick(1);
    count_check("R7", "flag set", start_flag, 1'b1);
    count_check("R8", "clock held", ck_oe, 1'b1);
    tick(3);
    count_check("R8", "clock still held", ck_oe, 1'b1);
    start_clr = 1;
    tick(1);
    count_check("R8", "clock released", ck_oe, 1'b0);
    di_line = 1; tick(3);

    // R9: overflow hold only in mode 11
    ovf_pulse = 1; tick(1);
    count_check("R9", "no hold in 10", ck_oe, 1'b0);
    mode = 2'b11; tick(1);
    count_check("R9", "hold in 11", ck_oe, 1'b1);
    // R10: set wins over clear
    ovf_pulse = 1; ovf_clr = 1; tick(1);
    count_check("R10", "set wins", ovf_flag, 1'b1);
    ovf_clr = 1; tick(1);
    count_check("R10", "cleared", ovf_flag, 1'b0);
    count_check("R9", "released in 11", ck_oe, 1'b0);

    // random phase across all modes
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) mode = 2'($urandom_range(0, 3));
      {shift_msb, do_port, do_dir, di_port, di_dir, ck_port, ck_dir} = 7'($urandom);
      if ($urandom_range(0, 3) == 0) di_line = ~di_line;
      if ($urandom_range(0, 5) == 0) ck_line = ~ck_line;
      ovf_pulse = ($urandom_range(0, 15) == 0);
      ovf_clr   = ($urandom_range(0, 7) == 0);
      start_clr = ($urandom_range(0, 7) == 0);
      tick(1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule